// File: doc/BRIEF.md
# Two-Level Translation Table Walker

The walker turns a 32-bit virtual address into a physical address by reading a two-level translation table from memory. A translation miss starts it. The walker takes the root table base from an area descriptor word. It reads one segment descriptor and then one page descriptor. At each level it checks validity, privilege and write permission. When the access is allowed, it writes the page descriptor back with its usage bits updated. It then reports the physical address and the cache attributes, or a fault code.

Memory is reached through a simple read/write port that allows one transaction at a time. A request stays asserted until the memory answers with an acknowledge. If the area descriptor has translation turned off, the walker passes the address through unchanged and makes no memory access.

Top module: `xlat_walker`

## Requirements
- R1: While reset is held and after it, `busy_o`, `done_o` and `mem_req_o` are 0.
- R2: If area descriptor bit 0 (translation enable) is 0, the walker reports `paddr_o` equal to the virtual address and fault code 0. It sets `attr_o` = {area bit 9, bit 7, bit 6} and makes no memory transaction.
- R3: The segment descriptor is read from {area[31:12], 12'b0} + vaddr[31:22]*4. The page descriptor is read from {seg[31:12], 12'b0} + vaddr[21:12]*4.
- R4: On success, `fault_code_o` is 0 and `paddr_o` = {page[31:12], vaddr[11:0]}. `attr_o` = {writethrough, global, cache inhibit} = descriptor bits {9,7,6}, ORed over the segment and page levels.
- R5: A segment descriptor with bit 0 (valid) equal to 0 ends the walk with fault code 1, after one transaction.
- R6: A page descriptor with bit 0 equal to 0 ends the walk with fault code 2, after two reads and no write-back.
- R7: If descriptor bit 8 (supervisor-only) is 1 at either level and `req_super_i` is 0, the walk ends with fault code 3. In supervisor mode the access is allowed.
- R8: If descriptor bit 2 (write-protect) is 1 at either level and `req_write_i` is 1, the walk ends with fault code 4. A read is allowed.
- R9: Within a level, the checks are taken in the order valid, supervisor, write-protect. All segment-level checks come before the page descriptor is read.
- R10: A successful walk writes the page descriptor back to its own address before `done_o`. Bit 3 (used) is set, bit 4 (modified) is set on a write, and all other bits are unchanged.
- R11: Once `mem_req_o` is raised, it stays high with stable `mem_addr_o`, `mem_we_o` and `mem_wdata_o` until `mem_ack_i`. Only one transaction is in flight at a time.
- R12: `done_o` is a one-cycle pulse. `req_valid_i` is ignored while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Start a walk (taken when idle) |
| req_vaddr_i | input | 32 | Virtual address |
| req_write_i | input | 1 | Access is a write |
| req_super_i | input | 1 | Access is made in supervisor mode |
| area_desc_i | input | 32 | Area descriptor: root base, enable and attribute bits |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Result valid for one cycle |
| paddr_o | output | 32 | Physical address |
| attr_o | output | 3 | {writethrough, global, cache inhibit} |
| fault_code_o | output | 3 | 0 none, 1 segment invalid, 2 page invalid, 3 supervisor, 4 write |
| mem_req_o | output | 1 | Memory transaction request |
| mem_we_o | output | 1 | Transaction is a write |
| mem_addr_o | output | 32 | Transaction byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Transaction complete; read data valid |
| mem_rdata_i | input | 32 | Read data |

## Verification
A single descriptor can trip both the supervisor check and the write-protect check in the same cycle. A segment descriptor that is supervisor-only and write-protected can also sit above a page descriptor that is invalid. The bench provokes both cases with user-mode writes to tables that have both bits set, or that have a bad page under a protected segment. It judges the result by the reported fault code and by the number of memory transactions. The supervisor code must win, and no page read may occur once the segment level has failed. A supervisor-mode write to the same tables must instead report the write fault.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // descriptor bit positions (shared by area, segment and page words)
  localparam int DB_VALID = 0;
  localparam int DB_TE    = 0;
  localparam int DB_WP    = 2;
  localparam int DB_USED  = 3;
  localparam int DB_MOD   = 4;
  localparam int DB_CI    = 6;
  localparam int DB_GLB   = 7;
  localparam int DB_SUP   = 8;
  localparam int DB_WT    = 9;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_SEG_INV = 3'd1,
    FLT_PG_INV  = 3'd2,
    FLT_SUPER   = 3'd3,
    FLT_WRITE   = 3'd4
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEG,
    ST_PAGE,
    ST_WBACK,
    ST_DONE
  } walk_state_e;

  function automatic logic [2:0] desc_attr(input logic [DB_WT:0] lo);
    return {lo[DB_WT], lo[DB_GLB], lo[DB_CI]};
  endfunction

endpackage

// File: rtl/xlat_addr_gen.sv
module xlat_addr_gen #(
  parameter int VA_W  = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic                  sel_page_i,
  input  logic [VA_W-OFF_W-1:0] root_base_i,
  input  logic [VA_W-OFF_W-1:0] seg_base_i,
  input  logic [IDX_W-1:0]      seg_idx_i,
  input  logic [IDX_W-1:0]      pg_idx_i,
  output logic [VA_W-1:0]       addr_o
);
  localparam int PFN_W = VA_W - OFF_W;

  logic [PFN_W-1:0] base;
  logic [IDX_W-1:0] idx;

  always_comb begin
    base   = sel_page_i ? seg_base_i : root_base_i;
    idx    = sel_page_i ? pg_idx_i   : seg_idx_i;
    addr_o = {base, {OFF_W{1'b0}}} + (VA_W'(idx) << 2);
  end
endmodule

// File: rtl/xlat_desc_check.sv
module xlat_desc_check
  import xlat_pkg::*;
#(
  parameter bit IS_PAGE = 1'b0
) (
  input  logic   valid_i,
  input  logic   super_only_i,
  input  logic   wprot_i,
  input  logic   priv_i,
  input  logic   write_i,
  output logic   fault_o,
  output fault_e code_o
);
  // priority: valid, then privilege, then write permission
  always_comb begin
    code_o = FLT_NONE;
    if (!valid_i)                  code_o = IS_PAGE ? FLT_PG_INV : FLT_SEG_INV;
    else if (super_only_i && !priv_i) code_o = FLT_SUPER;
    else if (wprot_i && write_i)   code_o = FLT_WRITE;
    fault_o = (code_o != FLT_NONE);
  end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [VA_W-1:0] req_vaddr_i,
  input  logic            req_write_i,
  input  logic            req_super_i,
  input  logic [VA_W-1:0] area_desc_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [VA_W-1:0] paddr_o,
  output logic [2:0]      attr_o,
  output logic [2:0]      fault_code_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [VA_W-1:0] mem_addr_o,
  output logic [VA_W-1:0] mem_wdata_o,
  input  logic            mem_ack_i,
  input  logic [VA_W-1:0] mem_rdata_i
);
  localparam int PFN_W  = VA_W - OFF_W;
  localparam int SEG_LO = OFF_W + IDX_W;
  localparam int NLVL   = 2;

  walk_state_e      state_q;
  logic [VA_W-1:0]  va_q;
  logic             wr_q, sup_q;
  logic [PFN_W-1:0] root_base_q, seg_base_q;
  logic [2:0]       seg_attr_q;
  logic [VA_W-1:0]  pg_q;
  logic [VA_W-1:0]  res_pa_q;
  logic [2:0]       res_attr_q;
  fault_e           res_code_q;

  logic [NLVL-1:0]  lvl_fault;
  fault_e           lvl_code [NLVL];
  logic [VA_W-1:0]  desc_addr;

  logic unused_area_bits;
  assign unused_area_bits = ^{area_desc_i[OFF_W-1:DB_WT+1], area_desc_i[DB_SUP],
                              area_desc_i[DB_CI-1:DB_TE+1]};

  // one checker per table level
  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    xlat_desc_check #(.IS_PAGE(g == 1)) u_chk (
      .valid_i      (mem_rdata_i[DB_VALID]),
      .super_only_i (mem_rdata_i[DB_SUP]),
      .wprot_i      (mem_rdata_i[DB_WP]),
      .priv_i       (sup_q),
      .write_i      (wr_q),
      .fault_o      (lvl_fault[g]),
      .code_o       (lvl_code[g])
    );
  end

  xlat_addr_gen #(.VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
    .sel_page_i  (state_q != ST_SEG),
    .root_base_i (root_base_q),
    .seg_base_i  (seg_base_q),
    .seg_idx_i   (va_q[VA_W-1:SEG_LO]),
    .pg_idx_i    (va_q[SEG_LO-1:OFF_W]),
    .addr_o      (desc_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      va_q        <= '0;
      wr_q        <= 1'b0;
      sup_q       <= 1'b0;
      root_base_q <= '0;
      seg_base_q  <= '0;
      seg_attr_q  <= '0;
      pg_q        <= '0;
      res_pa_q    <= '0;
      res_attr_q  <= '0;
      res_code_q  <= FLT_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          va_q        <= req_vaddr_i;
          wr_q        <= req_write_i;
          sup_q       <= req_super_i;
          root_base_q <= area_desc_i[VA_W-1:OFF_W];
          if (!area_desc_i[DB_TE]) begin
            res_pa_q   <= req_vaddr_i;
            res_attr_q <= desc_attr(area_desc_i[DB_WT:0]);
            res_code_q <= FLT_NONE;
            state_q    <= ST_DONE;
          end else begin
            state_q <= ST_SEG;
          end
        end
        ST_SEG: if (mem_ack_i) begin
          seg_base_q <= mem_rdata_i[VA_W-1:OFF_W];
          seg_attr_q <= desc_attr(mem_rdata_i[DB_WT:0]);
          if (lvl_fault[0]) begin
            res_code_q <= lvl_code[0];
            res_pa_q   <= '0;
            res_attr_q <= '0;
            state_q    <= ST_DONE;
          end else begin
            state_q <= ST_PAGE;
          end
        end
        ST_PAGE: if (mem_ack_i) begin
          pg_q <= mem_rdata_i;
          if (lvl_fault[1]) begin
            res_code_q <= lvl_code[1];
            res_pa_q   <= '0;
            res_attr_q <= '0;
            state_q    <= ST_DONE;
          end else begin
            res_code_q <= FLT_NONE;
            res_pa_q   <= {mem_rdata_i[VA_W-1:OFF_W], va_q[OFF_W-1:0]};
            res_attr_q <= seg_attr_q | desc_attr(mem_rdata_i[DB_WT:0]);
            state_q    <= ST_WBACK;
          end
        end
        ST_WBACK: if (mem_ack_i) state_q <= ST_DONE;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = (state_q == ST_SEG) || (state_q == ST_PAGE) || (state_q == ST_WBACK);
    mem_we_o    = (state_q == ST_WBACK);
    mem_addr_o  = desc_addr;
    mem_wdata_o = pg_q;
    mem_wdata_o[DB_USED] = 1'b1;
    if (wr_q) mem_wdata_o[DB_MOD] = 1'b1;
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = (state_q == ST_DONE);
  assign paddr_o      = res_pa_q;
  assign attr_o       = res_attr_q;
  assign fault_code_o = res_code_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                && $stable(mem_wdata_o)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R12
  AST_TE_OFF_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && req_valid_i && !area_desc_i[DB_TE] |=> done_o && !mem_req_o); // R2
  AST_SEG_INV_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_SEG && mem_ack_i && !mem_rdata_i[DB_VALID]
      |=> done_o && fault_code_o == FLT_SEG_INV); // R5
  AST_WB_USED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o[DB_USED]); // R10
  AST_WB_MOD_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && wr_q |-> mem_wdata_o[DB_MOD]); // R10
endmodule

// File: tb/tb_xlat_walker.sv
`timescale 1ns/1ps
module tb_xlat_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_super = 1'b0;
  logic [31:0] req_vaddr = '0, area_desc = '0;
  logic        busy, done, mem_req, mem_we;
  logic [31:0] paddr, mem_addr, mem_wdata;
  logic [2:0]  attr, fcode;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  xlat_walker dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_vaddr_i(req_vaddr),
    .req_write_i(req_write), .req_super_i(req_super), .area_desc_i(area_desc),
    .busy_o(busy), .done_o(done), .paddr_o(paddr), .attr_o(attr), .fault_code_o(fcode),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  // memory model: acknowledge after a fixed wait, log addresses, watch hold
  logic [31:0] mem [logic [31:0]];
  int          txn_cnt = 0, hold_viol = 0, wait_cnt = 0;
  logic [31:0] addr_log [4];
  logic [31:0] cap_addr = '0, cap_wd = '0;
  logic        cap_we = 1'b0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (wait_cnt == 0) begin
        cap_addr <= mem_addr; cap_we <= mem_we; cap_wd <= mem_wdata;
      end else if (mem_addr != cap_addr || mem_we != cap_we || mem_wdata != cap_wd) begin
        hold_viol <= hold_viol + 1;
      end
      if (wait_cnt == 2) begin
        wait_cnt  <= 0;
        mem_ack   <= 1'b1;
        mem_rdata <= rd(mem_addr);
        if (mem_we) mem[mem_addr] = mem_wdata;
        addr_log[txn_cnt[1:0]] <= mem_addr;
        txn_cnt <= txn_cnt + 1;
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic        sup;
    logic [2:0]  code;
    logic [31:0] pa;
    logic [2:0]  attr;
    logic [1:0]  txn;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{32'h00401123, 1'b0, 1'b0, 3'd0, 32'hABCDE123, 3'd0, 2'd3}, // R4 read
    '{32'h00401FFF, 1'b1, 1'b0, 3'd0, 32'hABCDEFFF, 3'd0, 2'd3}, // R4 R10 write
    '{32'h00801000, 1'b0, 1'b0, 3'd1, 32'h0,        3'd0, 2'd1}, // R5
    '{32'h00402000, 1'b0, 1'b0, 3'd2, 32'h0,        3'd0, 2'd2}, // R6
    '{32'h00C01000, 1'b0, 1'b0, 3'd3, 32'h0,        3'd0, 2'd1}, // R7 seg
    '{32'h00C01010, 1'b0, 1'b1, 3'd0, 32'hABCDE010, 3'd0, 2'd3}, // R7 seg, supervisor ok
    '{32'h00403000, 1'b0, 1'b0, 3'd3, 32'h0,        3'd0, 2'd2}, // R7 page
    '{32'h00403444, 1'b0, 1'b1, 3'd0, 32'h22222444, 3'd0, 2'd3}, // R7 page, supervisor ok
    '{32'h01001000, 1'b1, 1'b0, 3'd4, 32'h0,        3'd0, 2'd1}, // R8 seg
    '{32'h01001008, 1'b0, 1'b0, 3'd0, 32'hABCDE008, 3'd0, 2'd3}, // R8 seg, read ok
    '{32'h00404000, 1'b1, 1'b0, 3'd4, 32'h0,        3'd0, 2'd2}, // R8 page
    '{32'h00404ABC, 1'b0, 1'b1, 3'd0, 32'h33333ABC, 3'd0, 2'd3}, // R8 page, read ok
    '{32'h01401000, 1'b1, 1'b0, 3'd3, 32'h0,        3'd0, 2'd1}, // R9 sup over wp, seg
    '{32'h00405000, 1'b1, 1'b0, 3'd3, 32'h0,        3'd0, 2'd2}, // R9 sup over wp, page
    '{32'h01405000, 1'b1, 1'b1, 3'd4, 32'h0,        3'd0, 2'd1}, // R9 seg wp before page
    '{32'h01402000, 1'b0, 1'b0, 3'd3, 32'h0,        3'd0, 2'd1}, // R9 seg before page invalid
    '{32'h01806321, 1'b0, 1'b0, 3'd0, 32'h55555321, 3'd7, 2'd3}  // R4 attributes merged
  };

  function automatic string code_tag(input logic [2:0] c);
    case (c)
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      default: return "R4";
    endcase
  endfunction

  logic [2:0]  r_code, r_attr;
  logic [31:0] r_pa;
  int          r_tx;

  task automatic run(input logic [31:0] va, input logic wr, input logic sup, input logic [31:0] area);
    int base, cyc;
    @(negedge clk);
    base = txn_cnt;
    req_vaddr = va; req_write = wr; req_super = sup; area_desc = area; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
    chk(done, "R12 done seen", {31'b0, done}, 32'h1);
    r_code = fcode; r_pa = paddr; r_attr = attr; r_tx = txn_cnt - base;
    @(negedge clk);
    chk(!done && !busy, "R12 done one cycle", {30'b0, done, busy}, 32'h0);
  endtask

  localparam logic [31:0] AREA_ON = 32'h0001_0001;

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog R12 actual=hung expected=finished");
    report();
  end

  initial begin
    // root table at 0x10000, page table at 0x20000
    mem[32'h10004] = 32'h0002_0001;
    mem[32'h10008] = 32'h0003_0000;
    mem[32'h1000C] = 32'h0002_0101;
    mem[32'h10010] = 32'h0002_0005;
    mem[32'h10014] = 32'h0002_0105;
    mem[32'h10018] = 32'h0002_0201;
    mem[32'h20004] = 32'hABCD_E001;
    mem[32'h20008] = 32'h1111_1000;
    mem[32'h2000C] = 32'h2222_2101;
    mem[32'h20010] = 32'h3333_3005;
    mem[32'h20014] = 32'h4444_4105;
    mem[32'h20018] = 32'h5555_50C1;

    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req, "R1 in reset", {29'b0, busy, done, mem_req}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !mem_req, "R1 after reset", {29'b0, busy, done, mem_req}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t        v;
      logic [31:0] wb_a, old, seg_a;
      int          base;
      v     = VECS[i];
      wb_a  = 32'h20000 + {20'b0, v.va[21:12], 2'b00};
      seg_a = 32'h10000 + {20'b0, v.va[31:22], 2'b00};
      old   = rd(wb_a);
      base  = txn_cnt;
      run(v.va, v.wr, v.sup, AREA_ON);
      chk(r_code == v.code, {code_tag(v.code), " fault code"}, {29'b0, r_code}, {29'b0, v.code});
      chk(r_tx == int'(v.txn), "R5 R6 R9 transaction count", r_tx, {30'b0, v.txn});
      if (v.code == 3'd0) begin
        chk(r_pa == v.pa, "R4 paddr", r_pa, v.pa);
        chk(r_attr == v.attr, "R4 attr", {29'b0, r_attr}, {29'b0, v.attr});
        chk(rd(wb_a) == (old | 32'h8 | (v.wr ? 32'h10 : 32'h0)), "R10 write-back",
            rd(wb_a), old | 32'h8 | (v.wr ? 32'h10 : 32'h0));
        chk(addr_log[base[1:0]] == seg_a, "R3 segment address", addr_log[base[1:0]], seg_a);
        chk(addr_log[2'(base + 1)] == wb_a, "R3 page address", addr_log[2'(base + 1)], wb_a);
      end else begin
        chk(rd(wb_a) == old, "R6 no write-back on fault", rd(wb_a), old);
      end
    end

    // translation disabled: pass-through, area attributes, no memory use
    run(32'h1234_5678, 1'b1, 1'b0, 32'h0001_02C0);
    chk(r_pa == 32'h1234_5678, "R2 pass-through paddr", r_pa, 32'h1234_5678);
    chk(r_code == 3'd0, "R2 no fault", {29'b0, r_code}, 32'h0);
    chk(r_attr == 3'd7, "R2 area attributes", {29'b0, r_attr}, 32'h7);
    chk(r_tx == 0, "R2 no memory access", r_tx, 32'h0);

    // request held high while busy must not start or disturb a walk
    begin
      int base;
      @(negedge clk);
      base = txn_cnt;
      req_vaddr = 32'h0040_1555; req_write = 1'b0; req_super = 1'b0;
      area_desc = AREA_ON; req_valid = 1'b1;
      @(negedge clk);
      req_vaddr = 32'h0080_1000; req_write = 1'b1;
      repeat (4) @(negedge clk);
      req_valid = 1'b0;
      while (!done) @(negedge clk);
      chk(fcode == 3'd0 && paddr == 32'hABCD_E555, "R12 busy request ignored", paddr, 32'hABCD_E555);
      repeat (12) @(negedge clk);
      chk(!busy && txn_cnt - base == 3, "R12 no extra walk", txn_cnt - base, 32'h3);
    end

    chk(hold_viol == 0, "R11 request held stable", hold_viol, 32'h0);
    report();
  end
endmodule